// File: doc/BRIEF.md
# LPC Host Cycle Engine

This block turns one request at a time from a simple bus-side slave port into a single-byte I/O transaction on a 4-bit multiplexed LPC data bus, acting as the host. The requester presents a strobe together with a cycle tag, byte enables, a 16-bit I/O address, a direction bit and write data. The engine then runs the whole frame: the start nibble with the frame strobe low, the cycle-type nibble, four address nibbles and, for writes, two data nibbles. It follows these with a handover turnaround and a SYNC phase that tolerates wait codes. Reads take two nibbles of returned data. A final turnaround closes the frame, and the engine answers the bus side with a one-clock acknowledge that carries an error flag.

The data bus is split into a drive value, an output enable and a sampled input, so an I/O cell outside the block can form the tri-state pad. The bus side is a plain strobe/acknowledge handshake with no back-pressure beyond the acknowledge. The requester holds its strobe and fields steady until it sees `bus_ack` high, and drops the strobe in the following cycle. A new request is taken only when the engine is idle.

Top module: `lpc_host_engine`

## Requirements
- R1: While reset is applied and after it is released, with no request, `lframe_n` is 1, `lad_oe` is 0 and `bus_ack` is 0.
- R2: An accepted request produces exactly one cycle with `lframe_n` low, in the first cycle after the idle engine sees the strobe, with `lad_out` = 0000 and `lad_oe` = 1. `lframe_n` is high in every other cycle.
- R3: The cycle after the start cycle drives the cycle-type nibble 0000 for an I/O read and 0010 for an I/O write.
- R4: The next four cycles drive the 16-bit address one nibble at a time, bits 15:12 first and bits 3:0 last.
- R5: For a write, the next two cycles drive the data byte, bits 3:0 first, then bits 7:4.
- R6: After the address (read) or the data (write), the host drives 1111 with the enable on for one cycle, then turns `lad_oe` off for one cycle.
- R7: From the cycle after that turnaround, the host keeps `lad_oe` off and samples one SYNC code per cycle. On code 0000 a read samples two data nibbles on the next two cycles, bits 3:0 first, and returns them on `bus_rdata`. Two host-idle peripheral turnaround cycles follow, then the acknowledge.
- R8: SYNC code 1010, or any code other than 0000, 0101 and 0110, completes the frame the same way as 0000, data phase for reads included, but sets `bus_err` with the acknowledge.
- R9: SYNC code 0101 is a bounded wait. Up to 8 consecutive 0101 codes are tolerated. A 9th consecutive one ends SYNC at once with `bus_err` set and, for reads, no data phase and `bus_rdata` = 0. Any other code restarts the count.
- R10: SYNC code 0110 is an unbounded wait. The engine keeps sampling for as many cycles as it lasts, until a completing code appears.
- R11: Only tag 01 (I/O) with byte enables 0001 is accepted. Any other request is acknowledged on the next cycle with `bus_err` = 1 and `bus_rdata` = 0, and `lframe_n` stays high.
- R12: `bus_ack` is high for exactly one clock per request. For an accepted request it rises 14 cycles plus the number of SYNC cycles before the completing code after the strobe is first seen. A bounded-wait timeout makes it 20 cycles for a read and 22 for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_stb | input | 1 | Request strobe, held until acknowledge |
| bus_we | input | 1 | 1 = I/O write, 0 = I/O read |
| bus_tag | input | 2 | Cycle tag: 00 memory, 01 I/O, 10 firmware, 11 DMA |
| bus_sel | input | 4 | Byte enables; 0001 = single byte |
| bus_addr | input | 16 | I/O address |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, valid with acknowledge |
| bus_ack | output | 1 | One-clock completion pulse |
| bus_err | output | 1 | Error flag, high only with acknowledge |
| lad_in | input | 4 | Sampled LPC data nibble |
| lad_out | output | 4 | LPC data nibble to drive |
| lad_oe | output | 1 | Drive enable for `lad_out` |
| lframe_n | output | 1 | Active-low frame strobe |

## Verification
The hardest situation to reach is the edge of the bounded wait. Exactly eight consecutive short-wait codes must still complete, and the ninth must abort. A run of short waits that is split by a long wait must not abort, because the count restarts. The bench contains a peripheral model that replays a scripted list of SYNC codes, one per cycle, starting from the cycle in which the host has released the bus. Scripts with 8, 9 and split runs of short waits, long-wait runs and stray codes therefore land on exact cycles. The expected outcome and acknowledge latency are worked out from each script on its own.

// File: rtl/lpc_host_pkg.sv
package lpc_host_pkg;

  // One-hot engine states
  typedef enum logic [11:0] {
    ST_IDLE   = 12'h001,
    ST_START  = 12'h002,
    ST_CYCTYP = 12'h004,
    ST_ADDR   = 12'h008,
    ST_HDATA  = 12'h010,
    ST_HTAR1  = 12'h020,
    ST_HTAR2  = 12'h040,
    ST_SYNC   = 12'h080,
    ST_PDATA  = 12'h100,
    ST_PTAR1  = 12'h200,
    ST_PTAR2  = 12'h400,
    ST_RETIRE = 12'h800
  } eng_state_e;

  localparam logic [3:0] NIB_START  = 4'b0000;
  localparam logic [3:0] NIB_IDLE   = 4'b1111;
  localparam logic [3:0] CT_IO_RD   = 4'b0000;
  localparam logic [3:0] CT_IO_WR   = 4'b0010;

  localparam logic [3:0] SYNC_READY = 4'b0000;
  localparam logic [3:0] SYNC_SHORT = 4'b0101;
  localparam logic [3:0] SYNC_LONG  = 4'b0110;
  localparam logic [3:0] SYNC_FAIL  = 4'b1010;

  localparam logic [1:0] TAG_IO     = 2'b01;
  localparam logic [3:0] SEL_BYTE   = 4'b0001;

endpackage

// File: rtl/lpc_req_filter.sv
module lpc_req_filter
  import lpc_host_pkg::*;
(
  input  logic [1:0] tag,
  input  logic [3:0] sel,
  output logic       accept
);
  // Only single-byte I/O requests become bus frames
  assign accept = (tag == TAG_IO) && (sel == SEL_BYTE);
endmodule

// File: rtl/lpc_sync_watch.sv
module lpc_sync_watch
  import lpc_host_pkg::*;
#(
  parameter int SHORT_MAX = 8,
  localparam int CW = $clog2(SHORT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_en,
  input  logic [3:0]    code,
  output logic          done,
  output logic          fail,
  output logic          timeout,
  output logic [CW-1:0] wait_cnt
);
  logic is_short, is_long, is_ready;

  assign is_short = (code == SYNC_SHORT);
  assign is_long  = (code == SYNC_LONG);
  assign is_ready = (code == SYNC_READY);

  assign timeout = sample_en && is_short && (wait_cnt == CW'(SHORT_MAX));
  assign done    = sample_en && !is_short && !is_long;
  assign fail    = done && !is_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_cnt <= '0;
    end else if (sample_en && is_short && !timeout) begin
      wait_cnt <= wait_cnt + CW'(1);
    end else begin
      wait_cnt <= '0;
    end
  end
endmodule

// File: rtl/lpc_nibble_drive.sv
module lpc_nibble_drive
  import lpc_host_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int ADDR_NIBS = ADDR_W / 4,
  localparam int IDX_W = (ADDR_NIBS > 2) ? $clog2(ADDR_NIBS) : 1
) (
  input  eng_state_e        state,
  input  logic [IDX_W-1:0]  idx,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic              lframe_n
);
  logic [3:0] addr_nib [ADDR_NIBS];

  // Most-significant nibble sits at index 0
  for (genvar g = 0; g < ADDR_NIBS; g++) begin : g_nib
    assign addr_nib[g] = addr[ADDR_W-1-4*g -: 4];
  end

  always_comb begin
    lad_out  = NIB_IDLE;
    lad_oe   = 1'b0;
    lframe_n = 1'b1;
    unique case (state)
      ST_START: begin
        lad_out  = NIB_START;
        lad_oe   = 1'b1;
        lframe_n = 1'b0;
      end
      ST_CYCTYP: begin
        lad_out = we ? CT_IO_WR : CT_IO_RD;
        lad_oe  = 1'b1;
      end
      ST_ADDR: begin
        lad_out = addr_nib[idx];
        lad_oe  = 1'b1;
      end
      ST_HDATA: begin
        lad_out = idx[0] ? wdata[7:4] : wdata[3:0];
        lad_oe  = 1'b1;
      end
      ST_HTAR1: begin
        lad_out = NIB_IDLE;
        lad_oe  = 1'b1;
      end
      default: begin
        lad_out  = NIB_IDLE;
        lad_oe   = 1'b0;
        lframe_n = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/lpc_host_engine.sv
module lpc_host_engine
  import lpc_host_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SHORT_WAIT_MAX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [1:0]        bus_tag,
  input  logic [3:0]        bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_ack,
  output logic              bus_err,
  input  logic [3:0]        lad_in,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic              lframe_n
);
  localparam int ADDR_NIBS = ADDR_W / 4;
  localparam int IDX_W     = (ADDR_NIBS > 2) ? $clog2(ADDR_NIBS) : 1;
  localparam int WAIT_CW   = $clog2(SHORT_WAIT_MAX + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ADDR_NIBS - 1);
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

  eng_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;
  logic [7:0]        rdata_q;
  logic              err_q;

  logic               accept;
  logic               sync_done, sync_fail, sync_timeout;
  logic [WAIT_CW-1:0] wait_cnt;

  lpc_req_filter u_filter (
    .tag    (bus_tag),
    .sel    (bus_sel),
    .accept (accept)
  );

  lpc_sync_watch #(.SHORT_MAX(SHORT_WAIT_MAX)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (state_q == ST_SYNC),
    .code      (lad_in),
    .done      (sync_done),
    .fail      (sync_fail),
    .timeout   (sync_timeout),
    .wait_cnt  (wait_cnt)
  );

  lpc_nibble_drive #(.ADDR_W(ADDR_W)) u_drive (
    .state    (state_q),
    .idx      (idx_q),
    .we       (we_q),
    .addr     (addr_q),
    .wdata    (wdata_q),
    .lad_out  (lad_out),
    .lad_oe   (lad_oe),
    .lframe_n (lframe_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          idx_q <= '0;
          if (bus_stb) begin
            rdata_q <= '0;
            if (accept) begin
              state_q <= ST_START;
              we_q    <= bus_we;
              addr_q  <= bus_addr;
              wdata_q <= bus_wdata;
              err_q   <= 1'b0;
            end else begin
              state_q <= ST_RETIRE;
              err_q   <= 1'b1;
            end
          end
        end
        ST_START:  state_q <= ST_CYCTYP;
        ST_CYCTYP: begin
          state_q <= ST_ADDR;
          idx_q   <= '0;
        end
        ST_ADDR: begin
          if (idx_q == IDX_LAST) begin
            idx_q   <= '0;
            state_q <= we_q ? ST_HDATA : ST_HTAR1;
          end else begin
            idx_q <= idx_q + IDX_ONE;
          end
        end
        ST_HDATA: begin
          if (idx_q == IDX_ONE) begin
            idx_q   <= '0;
            state_q <= ST_HTAR1;
          end else begin
            idx_q <= idx_q + IDX_ONE;
          end
        end
        ST_HTAR1: state_q <= ST_HTAR2;
        ST_HTAR2: state_q <= ST_SYNC;
        ST_SYNC: begin
          if (sync_timeout) begin
            err_q   <= 1'b1;
            state_q <= ST_PTAR1;
          end else if (sync_done) begin
            err_q   <= sync_fail;
            state_q <= we_q ? ST_PTAR1 : ST_PDATA;
            idx_q   <= '0;
          end
        end
        ST_PDATA: begin
          if (idx_q == IDX_ONE) begin
            rdata_q[7:4] <= lad_in;
            idx_q        <= '0;
            state_q      <= ST_PTAR1;
          end else begin
            rdata_q[3:0] <= lad_in;
            idx_q        <= idx_q + IDX_ONE;
          end
        end
        ST_PTAR1:  state_q <= ST_PTAR2;
        ST_PTAR2:  state_q <= ST_RETIRE;
        ST_RETIRE: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_ack   = (state_q == ST_RETIRE);
  assign bus_err   = bus_ack && err_q;
  assign bus_rdata = rdata_q;

endmodule

// File: rtl/lpc_host_checker.sv
module lpc_host_checker
  import lpc_host_pkg::*;
#(
  parameter int SHORT_WAIT_MAX = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input eng_state_e    state_q,
  input logic          lframe_n,
  input logic          lad_oe,
  input logic [3:0]    lad_out,
  input logic          bus_stb,
  input logic          bus_ack,
  input logic          bus_err,
  input logic          accept,
  input logic [CW-1:0] wait_cnt
);

  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_q) == 1); // R12

  AST_FRAME_IS_START: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |-> (lad_oe && lad_out == 4'b0000)); // R2

  AST_FRAME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |=> lframe_n); // R2

  AST_HANDOFF_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HTAR1) |-> (lad_oe && lad_out == 4'b1111)); // R6

  AST_HANDOFF_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HTAR1) |=> !lad_oe); // R6

  AST_PERIPH_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SYNC || state_q == ST_PDATA || state_q == ST_PTAR1 ||
     state_q == ST_PTAR2) |-> !lad_oe); // R7

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack); // R12

  AST_ERR_ONLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_ack); // R8

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= CW'(SHORT_WAIT_MAX)); // R9

  AST_REJECT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && bus_stb && !accept) |=> (bus_ack && bus_err && lframe_n)); // R11

endmodule

bind lpc_host_engine lpc_host_checker #(
  .SHORT_WAIT_MAX (SHORT_WAIT_MAX),
  .CW             (WAIT_CW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .state_q  (state_q),
  .lframe_n (lframe_n),
  .lad_oe   (lad_oe),
  .lad_out  (lad_out),
  .bus_stb  (bus_stb),
  .bus_ack  (bus_ack),
  .bus_err  (bus_err),
  .accept   (accept),
  .wait_cnt (wait_cnt)
);

// File: tb/lpc_host_engine_tb.sv
`timescale 1ns/1ps
module lpc_host_engine_tb;

  typedef struct {
    string      req;
    logic       we;
    logic [15:0] addr;
    logic [7:0] wdata;
    logic       lpc;
    logic [3:0] pscr [48];
    int         pn;
    logic       err;
    logic [7:0] rdata;
    int         lat;
    int         t0;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_stb = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_tag = 2'b01;
  logic [3:0]  bus_sel = 4'b0001;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_ack, bus_err;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  lad_out;
  logic        lad_oe, lframe_n;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;
  item_t exp_q [$];
  logic [3:0] scr [32];
  int scr_n = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lpc_host_engine u_dut (
    .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_tag(bus_tag), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .bus_err(bus_err), .lad_in(lad_in), .lad_out(lad_out),
    .lad_oe(lad_oe), .lframe_n(lframe_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic scr_clear();
    scr_n = 0;
  endtask

  task automatic scr_add(input logic [3:0] code, input int n);
    for (int i = 0; i < n; i++) begin
      scr[scr_n] = code;
      scr_n++;
    end
  endtask

  // Driver: builds the expected item from the requirements, then drives it
  task automatic run_txn(input string req, input logic we, input logic [1:0] tag,
                         input logic [3:0] sel, input logic [15:0] addr,
                         input logic [7:0] wdata, input logic [7:0] rbyte);
    item_t it;
    int cnt, nsync;
    logic tmo;
    it.req = req; it.we = we; it.addr = addr; it.wdata = wdata;
    it.lpc = (tag == 2'b01) && (sel == 4'b0001);
    it.pn = 0;
    if (!it.lpc) begin
      it.err = 1'b1; it.rdata = 8'h00; it.lat = 1;
    end else begin
      cnt = 0; nsync = 0; tmo = 1'b0; it.err = 1'b0;
      for (int i = 0; i < scr_n; i++) begin
        nsync = i + 1;
        it.pscr[i] = scr[i];
        it.pn = i + 1;
        if (scr[i] == 4'b0101) begin
          if (cnt == 8) begin tmo = 1'b1; break; end
          cnt++;
        end else if (scr[i] == 4'b0110) begin
          cnt = 0;
        end else begin
          it.err = (scr[i] != 4'b0000);
          break;
        end
      end
      if (tmo) it.err = 1'b1;
      if (!we && !tmo) begin
        it.pscr[it.pn] = rbyte[3:0];
        it.pscr[it.pn + 1] = rbyte[7:4];
        it.pn += 2;
      end
      it.rdata = (!we && !tmo) ? rbyte : 8'h00;
      it.lat = 1 + 2 + 4 + (we ? 2 : 0) + 2 + nsync + ((!we && !tmo) ? 2 : 0) + 2;
    end
    @(negedge clk);
    it.t0 = cyc;
    exp_q.push_back(it);
    bus_stb = 1'b1; bus_we = we; bus_tag = tag; bus_sel = sel;
    bus_addr = addr; bus_wdata = wdata;
    do @(negedge clk); while (!bus_ack && !finished);
    bus_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Peripheral model: checks the host nibbles, replays the SYNC script
  initial begin
    int p = 0;
    int k = 0;
    int dp = 0;
    item_t cur;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        p = 0; lad_in = 4'hF;
      end else if (p == 0) begin
        lad_in = 4'hF;
        if (!lframe_n) begin
          if (exp_q.size() == 0 || !exp_q[0].lpc) begin
            chk("R11 frame on rejected request", 32'd1, 32'd0);
          end else begin
            cur = exp_q[0];
            dp = cur.we ? 2 : 0;
            chk("R2 start nibble", {27'd0, lad_oe, lad_out}, {27'd0, 1'b1, 4'h0});
            p = 1;
          end
        end
      end else begin
        if (bus_ack) begin
          p = 0; lad_in = 4'hF;
        end else begin
          if (p == 1) begin
            chk("R2 frame strobe single", {31'd0, lframe_n}, 32'd1);
            chk("R3 cycle type", {28'd0, lad_out}, cur.we ? 32'h2 : 32'h0);
          end else if (p >= 2 && p <= 5) begin
            chk("R4 address nibble", {27'd0, lad_oe, lad_out},
                {27'd0, 1'b1, cur.addr[15-4*(p-2) -: 4]});
          end else if (p >= 6 && p < 6 + dp) begin
            chk("R5 write nibble", {27'd0, lad_oe, lad_out},
                {27'd0, 1'b1, (p == 6) ? cur.wdata[3:0] : cur.wdata[7:4]});
          end else if (p == 6 + dp) begin
            chk("R6 turnaround drive", {27'd0, lad_oe, lad_out}, {27'd0, 1'b1, 4'hF});
          end else if (p == 7 + dp) begin
            chk("R6 turnaround float", {31'd0, lad_oe}, 32'd0);
            k = 0;
          end else begin
            if (lad_oe) chk("R7 host off bus after handover", 32'd1, 32'd0);
            if (!lframe_n) chk("R2 frame strobe only at start", 32'd1, 32'd0);
            if (k < cur.pn) begin
              lad_in = cur.pscr[k];
              k++;
            end else begin
              lad_in = 4'hF;
            end
          end
          p++;
        end
      end
    end
  end

  // Monitor: pops the scoreboard on every acknowledge
  initial begin
    logic ack_prev = 1'b0;
    item_t it;
    forever begin
      @(negedge clk);
      if (ack_prev && bus_ack) chk("R12 ack longer than one clock", 32'd1, 32'd0);
      ack_prev = bus_ack;
      if (rst_n && bus_ack) begin
        if (exp_q.size() == 0) begin
          chk("R12 unexpected ack", 32'd1, 32'd0);
        end else begin
          it = exp_q.pop_front();
          chk({it.req, " R12 latency"}, 32'(cyc - it.t0), 32'(it.lat));
          chk({it.req, " error flag"}, {31'd0, bus_err}, {31'd0, it.err});
          if (!it.we) chk({it.req, " read data"}, {24'd0, bus_rdata}, {24'd0, it.rdata});
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog expired", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset lframe_n", {31'd0, lframe_n}, 32'd1);
    chk("R1 reset lad_oe", {31'd0, lad_oe}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle outputs", {29'd0, lframe_n, lad_oe, bus_ack}, {29'd0, 3'b100});

    scr_clear(); scr_add(4'b0000, 1);
    run_txn("R7 read ready", 1'b0, 2'b01, 4'b0001, 16'h03F8, 8'h00, 8'hA5);
    run_txn("R5 write ready", 1'b1, 2'b01, 4'b0001, 16'hFFF0, 8'h3C, 8'h00);

    scr_clear(); scr_add(4'b0101, 3); scr_add(4'b0000, 1);
    run_txn("R9 read three short waits", 1'b0, 2'b01, 4'b0001, 16'h1234, 8'h00, 8'h5A);

    scr_clear(); scr_add(4'b0101, 8); scr_add(4'b0000, 1);
    run_txn("R9 read eight short waits", 1'b0, 2'b01, 4'b0001, 16'h8001, 8'h00, 8'hC3);

    scr_clear(); scr_add(4'b0101, 9); scr_add(4'b0000, 1);
    run_txn("R9 read short wait timeout", 1'b0, 2'b01, 4'b0001, 16'h0060, 8'h00, 8'h77);

    scr_clear(); scr_add(4'b0101, 9);
    run_txn("R9 write short wait timeout", 1'b1, 2'b01, 4'b0001, 16'h0064, 8'h99, 8'h00);

    scr_clear(); scr_add(4'b0110, 20); scr_add(4'b0000, 1);
    run_txn("R10 read long wait", 1'b0, 2'b01, 4'b0001, 16'hBEEF, 8'h00, 8'h1E);

    scr_clear(); scr_add(4'b0101, 6); scr_add(4'b0110, 1); scr_add(4'b0101, 6);
    scr_add(4'b0000, 1);
    run_txn("R9 split short runs", 1'b1, 2'b01, 4'b0001, 16'h4321, 8'hE1, 8'h00);

    scr_clear(); scr_add(4'b1010, 1);
    run_txn("R8 read error code", 1'b0, 2'b01, 4'b0001, 16'h02E8, 8'h00, 8'h6B);

    scr_clear(); scr_add(4'b0110, 2); scr_add(4'b1010, 1);
    run_txn("R8 write error code", 1'b1, 2'b01, 4'b0001, 16'h0378, 8'h42, 8'h00);

    scr_clear(); scr_add(4'b0011, 1);
    run_txn("R8 stray code", 1'b0, 2'b01, 4'b0001, 16'h0070, 8'h00, 8'hD2);

    scr_clear(); scr_add(4'b0000, 1);
    run_txn("R11 memory tag", 1'b0, 2'b00, 4'b0001, 16'h1000, 8'h00, 8'h00);
    run_txn("R11 dma tag", 1'b1, 2'b11, 4'b0001, 16'h1000, 8'h11, 8'h00);
    run_txn("R11 two-byte select", 1'b0, 2'b01, 4'b0011, 16'h1000, 8'h00, 8'h00);

    run_txn("R7 read after rejects", 1'b0, 2'b01, 4'b0001, 16'h0080, 8'h00, 8'h81);

    repeat (4) @(negedge clk);
    chk("R12 scoreboard drained", 32'(exp_q.size()), 32'd0);
    chk("R1 idle after traffic", {30'd0, lframe_n, lad_oe}, {30'd0, 2'b10});
    finish_run();
  end

endmodule